// File: doc/BRIEF.md
# Push-Button Power-Rail Sequencer

This block is the digital sequencing core of a power-management controller. It brings up a set of seven rail enables in a fixed order when either a push-button is pressed or a charger supply becomes valid. The primary rail comes up first. Once that rail reports power-good, two secondary rails follow and the processor is held in reset. After a programmable timeout the reset is released, but only if the primary rail is still good at that moment. Two further rails follow the processor's own enable request. Two auxiliary rails follow a register-driven request while the sequencer is active.

The processor has to claim the boot by asserting its hold input or its enable input. If the button is released, or the charger indication goes away, before either of those is asserted, the sequencer drops every rail and returns to off. This rejects accidental presses. In normal operation a short button press only pulls the status output low so that the processor is interrupted. A long press forces a manual processor reset. Dropping both hold and enable shuts the system down, and dropping only enable gives a sleep state in which the processor rails are off.

Every external input passes through a two-flop synchroniser. The button is also debounced.

Top module: `pbseq_top`

## Requirements
- R1: From off, a debounced button press (pb_n low) or a rising edge of chg_valid turns on rail 1 (rail_en[0]) alone, with cpu_rst_n held low.
- R2: When rail 1 reports power-good, rails 2 and 5 (rail_en[1], rail_en[4]) turn on while cpu_rst_n stays low.
- R3: cpu_rst_n rises exactly RST_CYCLES clock cycles after rails 2 and 5 turn on, if rail1_pgood is high at expiry. If rail1_pgood is low at expiry, cpu_rst_n stays low and the count restarts.
- R4: During boot, if the start condition (button held or chg_valid high) goes away while neither cpu_hold nor cpu_enable is high, every rail turns off together and the sequencer returns to off.
- R5: A boot claimed through cpu_hold or cpu_enable keeps rails 1, 2 and 5 on after the start condition goes away.
- R6: Once the boot has been claimed or the processor reset has been released, rails 3 and 4 (rail_en[2], rail_en[3]) follow cpu_enable. With cpu_enable low and cpu_hold high, rails 1, 2 and 5 stay on (sleep).
- R7: In normal operation, cpu_hold and cpu_enable both low turns every rail off.
- R8: A button press in normal operation drives pb_stat_n low and leaves the rails unchanged. pb_stat_n is high while off or booting.
- R9: A button held for MR_CYCLES debounced cycles in normal operation drives cpu_rst_n low on the next cycle. It stays low while the button is held and rises RST_CYCLES+1 cycles after pb_stat_n returns high.
- R10: Rails 6 and 7 (rail_en[5], rail_en[6]) follow aux_rail_req[0] and aux_rail_req[1] whenever rail 1 is on, and are forced off while off.
- R11: A button pulse shorter than DEB_CYCLES synchronised cycles does not start a boot.
- R12: After reset, all rails are off, cpu_rst_n is low and pb_stat_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_n | input | 1 | Push-button, active low |
| chg_valid | input | 1 | Charger supply valid |
| rail1_pgood | input | 1 | Rail 1 power-good |
| cpu_hold | input | 1 | Processor hold request |
| cpu_enable | input | 1 | Processor enable request for rails 3 and 4 |
| aux_rail_req | input | 2 | Register-driven requests for rails 6 and 7 |
| rail_en | output | 7 | Rail enables, bit i is rail i+1 |
| cpu_rst_n | output | 1 | Processor reset, active low |
| pb_stat_n | output | 1 | Button status to the processor, active low |

## Verification
The sequencer state is visible almost directly in the rail enables, so a wrong state shows up in the cycle after the faulty transition. A rail group switches out of turn, or all of them collapse. A timer loaded with the wrong count or restarted at the wrong time shifts the cpu_rst_n release by a fixed number of cycles. That shift is measured exactly, both from the secondary-rail rise and from the pb_stat_n release after a manual reset. A missed claim check or debounce fault shows up within a few tens of cycles as rails that stay on or come on when they should not.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
  typedef enum logic [2:0] {
    S_OFF     = 3'd0,
    S_PRIMARY = 3'd1,
    S_BOOTRST = 3'd2,
    S_BOOTRUN = 3'd3,
    S_RUN     = 3'd4,
    S_MRHOLD  = 3'd5,
    S_MRWAIT  = 3'd6
  } seq_state_t;

  localparam int NUM_RAILS = 7;
  localparam int NUM_AUX   = 2;
endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/pbseq_debounce.sv
module pbseq_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic pressed
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          pressed_q, pressed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    pressed_d = pressed_q;
    cnt_d     = '0;
    cnt_en    = 1'b0;
    if (!raw_n != pressed_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        pressed_d = !raw_n;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      pressed_q <= pressed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pressed = pressed_q;
endmodule

// File: rtl/pbseq_timer.sv
module pbseq_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign expired = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
  import pbseq_pkg::*;
#(
  parameter int MR_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn,
  input  logic       chg,
  input  logic       pg1,
  input  logic       hold,
  input  logic       en,
  input  logic       tmr_expired,
  output logic       tmr_start,
  output seq_state_t state
);
  localparam int MW = $clog2(MR_CYCLES + 1);
  localparam logic [MW-1:0] MR_LAST = MW'(MR_CYCLES - 1);

  seq_state_t    state_q, state_d;
  logic [MW-1:0] mr_q, mr_d;
  logic          mr_en;
  logic          chg_q;
  logic          chg_rise, claim, trig;

  assign chg_rise = chg && !chg_q;
  assign claim    = hold || en;
  assign trig     = btn || chg;

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    unique case (state_q)
      S_OFF: begin
        if (btn || chg_rise) state_d = S_PRIMARY;
      end
      S_PRIMARY: begin
        if (!trig && !claim) begin
          state_d = S_OFF;
        end else if (pg1) begin
          state_d   = S_BOOTRST;
          tmr_start = 1'b1;
        end
      end
      S_BOOTRST: begin
        if (!trig && !claim) begin
          state_d = S_OFF;
        end else if (tmr_expired) begin
          if (pg1) state_d = S_BOOTRUN;
          else     tmr_start = 1'b1;
        end
      end
      S_BOOTRUN: begin
        if (!trig) state_d = claim ? S_RUN : S_OFF;
      end
      S_RUN: begin
        if (!claim)                     state_d = S_OFF;
        else if (btn && mr_q == MR_LAST) state_d = S_MRHOLD;
      end
      S_MRHOLD: begin
        if (!claim) begin
          state_d = S_OFF;
        end else if (!btn) begin
          state_d   = S_MRWAIT;
          tmr_start = 1'b1;
        end
      end
      S_MRWAIT: begin
        if (!claim)           state_d = S_OFF;
        else if (btn)         state_d = S_MRHOLD;
        else if (tmr_expired) state_d = S_RUN;
      end
      default: state_d = S_OFF;
    endcase
  end

  // long-press counter, active only in normal operation
  always_comb begin
    mr_d  = '0;
    mr_en = 1'b0;
    if (state_q == S_RUN && btn) begin
      mr_en = (mr_q != MR_LAST);
      mr_d  = mr_q + 1'b1;
    end else if (mr_q != '0) begin
      mr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      mr_q    <= '0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= chg;
      if (mr_en) mr_q <= mr_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
  import pbseq_pkg::*;
#(
  parameter int DEB_CYCLES = 4,
  parameter int RST_CYCLES = 32,
  parameter int MR_CYCLES  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pb_n,
  input  logic       chg_valid,
  input  logic       rail1_pgood,
  input  logic       cpu_hold,
  input  logic       cpu_enable,
  input  logic [1:0] aux_rail_req,
  output logic [6:0] rail_en,
  output logic       cpu_rst_n,
  output logic       pb_stat_n
);
  localparam int SW = 5 + NUM_AUX;

  logic [SW-1:0] raw_in, syn_in;
  logic          pb_s, chg_s, pg1_s, hold_s, en_s;
  logic [NUM_AUX-1:0] aux_s;
  logic          btn, tmr_start, tmr_expired;
  seq_state_t    state;
  logic          st_on, st_sec, st_cpu, st_norm;

  assign raw_in = {aux_rail_req, cpu_enable, cpu_hold, rail1_pgood, chg_valid, pb_n};

  pbseq_sync #(.WIDTH(SW), .RST_VAL(32'd1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {aux_s, en_s, hold_s, pg1_s, chg_s, pb_s} = syn_in;

  pbseq_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_n(pb_s), .pressed(btn)
  );

  pbseq_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .expired(tmr_expired)
  );

  pbseq_fsm #(.MR_CYCLES(MR_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .btn(btn), .chg(chg_s), .pg1(pg1_s),
    .hold(hold_s), .en(en_s), .tmr_expired(tmr_expired),
    .tmr_start(tmr_start), .state(state)
  );

  assign st_on   = (state != S_OFF);
  assign st_sec  = st_on && (state != S_PRIMARY);
  assign st_cpu  = st_sec && (state != S_BOOTRST);
  assign st_norm = (state == S_RUN) || (state == S_MRHOLD) || (state == S_MRWAIT);

  assign rail_en[0]   = st_on;
  assign rail_en[1]   = st_sec;
  assign rail_en[2]   = st_cpu && en_s;
  assign rail_en[3]   = st_cpu && en_s;
  assign rail_en[4]   = st_sec;
  assign rail_en[6:5] = aux_s & {NUM_AUX{st_on}};

  assign cpu_rst_n = (state == S_BOOTRUN) || (state == S_RUN);
  assign pb_stat_n = !(btn && st_norm);
endmodule

// File: rtl/pbseq_checker.sv
module pbseq_checker
  import pbseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] rail_en,
  input logic       cpu_rst_n,
  input logic       pb_stat_n,
  input seq_state_t state
);
  p_sec_after_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> (rail_en[0] && !cpu_rst_n));

  p_release_with_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (rail_en[1] && rail_en[4]));

  p_all_drop_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[0]) |-> (rail_en == 7'd0));

  p_cpu_rails_need_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en[2] |-> (rail_en[1] && rail_en[4] && rail_en[0]));

  p_quiet_status_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en[0] |-> pb_stat_n);

  p_manual_reset_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MRHOLD) |-> !cpu_rst_n);

  p_aux_forced_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en[0] |-> (rail_en[6:5] == 2'b00));

  p_reset_low_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en[0] |-> !cpu_rst_n);
endmodule

bind pbseq_top pbseq_checker u_pbseq_checker (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .cpu_rst_n(cpu_rst_n),
  .pb_stat_n(pb_stat_n), .state(u_fsm.state_q)
);

// File: tb/pbseq_top_bench.sv
`timescale 1ns/1ps
module pbseq_top_bench;
  localparam int RSTC = 32;

  logic       clk, rst_n, pb_n, chg_valid, rail1_pgood, cpu_hold, cpu_enable;
  logic [1:0] aux_rail_req;
  logic [6:0] rail_en;
  logic       cpu_rst_n, pb_stat_n;

  int checks = 0;
  int errors = 0;

  pbseq_top u_pbseq_top (
    .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .chg_valid(chg_valid),
    .rail1_pgood(rail1_pgood), .cpu_hold(cpu_hold), .cpu_enable(cpu_enable),
    .aux_rail_req(aux_rail_req), .rail_en(rail_en), .cpu_rst_n(cpu_rst_n),
    .pb_stat_n(pb_stat_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] exp_rails(input logic sec, input logic cpu,
                                           input logic en, input logic [1:0] aux);
    logic [6:0] r;
    r      = '0;
    r[0]   = 1'b1;
    r[1]   = sec;
    r[4]   = sec;
    r[2]   = cpu && en;
    r[3]   = cpu && en;
    r[6:5] = aux;
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rail2(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (rail_en[1]) seen = 1;
    end
  endtask

  task automatic count_to_release(output int n);
    n = 0;
    while (!cpu_rst_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    logic [1:0] aux_r;
    logic en_r;
    n = int'($urandom(32'h5EED_0042));
    rst_n = 1'b0; pb_n = 1'b1; chg_valid = 1'b0; rail1_pgood = 1'b0;
    cpu_hold = 1'b0; cpu_enable = 1'b0; aux_rail_req = 2'b00;
    cyc(3);
    check(rail_en == 0 && !cpu_rst_n && pb_stat_n, "R12 reset state",
          {rail_en, cpu_rst_n, pb_stat_n}, 32'h1);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);

    // R11: short glitch ignored
    pb_n = 1'b0; cyc(2); pb_n = 1'b1; cyc(20);
    check(rail_en == 0, "R11 short pulse ignored", rail_en, 0);

    // R1: button start, rail 1 alone
    pb_n = 1'b0; cyc(20);
    check(rail_en == 7'b0000001 && !cpu_rst_n, "R1 primary only", rail_en, 1);

    // R2 / R3: power-good then exact reset length
    rail1_pgood = 1'b1;
    wait_rail2(seen);
    check(seen && rail_en[4] && !cpu_rst_n, "R2 secondary rails with reset low",
          {rail_en, cpu_rst_n}, {7'b0010011, 1'b0});
    count_to_release(n);
    check(n == RSTC, "R3 reset timeout length", n, RSTC);

    // R4: release without claim
    pb_n = 1'b1; cyc(20);
    check(rail_en == 0, "R4 unclaimed boot dropped", rail_en, 0);

    // R5 / R6: claimed boot
    pb_n = 1'b0; wait_rail2(seen); count_to_release(n);
    cpu_hold = 1'b1; cpu_enable = 1'b1; cyc(4);
    pb_n = 1'b1; cyc(20);
    check(rail_en == exp_rails(1, 1, 1, 2'b00) && cpu_rst_n, "R5 claimed boot stays up",
          rail_en, exp_rails(1, 1, 1, 2'b00));

    // R6 / R10: random enable and aux requests
    for (int k = 0; k < 40; k++) begin
      en_r  = 1'($urandom);
      aux_r = 2'($urandom);
      cpu_enable = en_r; aux_rail_req = aux_r;
      cyc(4);
      check(rail_en == exp_rails(1, 1, en_r, aux_r), "R6 R10 rails follow requests",
            rail_en, exp_rails(1, 1, en_r, aux_r));
    end

    // R6: sleep
    cpu_enable = 1'b0; aux_rail_req = 2'b00; cyc(4);
    check(rail_en == exp_rails(1, 1, 0, 2'b00), "R6 sleep keeps 1,2,5",
          rail_en, exp_rails(1, 1, 0, 2'b00));
    cpu_enable = 1'b1; cyc(4);

    // R8: short press interrupts only
    pb_n = 1'b0; cyc(9);
    check(!pb_stat_n, "R8 status low on press", pb_stat_n, 0);
    check(rail_en == exp_rails(1, 1, 1, 2'b00) && cpu_rst_n, "R8 rails unchanged",
          rail_en, exp_rails(1, 1, 1, 2'b00));
    pb_n = 1'b1; cyc(20);
    check(pb_stat_n && cpu_rst_n, "R8 status high after release",
          {pb_stat_n, cpu_rst_n}, 2'b11);

    // R9: long press manual reset
    pb_n = 1'b0; cyc(90);
    check(!cpu_rst_n, "R9 reset low during long press", cpu_rst_n, 0);
    pb_n = 1'b1;
    n = 0;
    while (!pb_stat_n && n < 100) begin @(negedge clk); n++; end
    check(!cpu_rst_n, "R9 reset still low at status release", cpu_rst_n, 0);
    count_to_release(n);
    check(n == RSTC + 1, "R9 reset release after manual reset", n, RSTC + 1);

    // R7 / R10: shutdown by processor
    aux_rail_req = 2'b11; cyc(4);
    check(rail_en[6:5] == 2'b11, "R10 aux on while running", rail_en[6:5], 3);
    cpu_hold = 1'b0; cpu_enable = 1'b0; cyc(5);
    check(rail_en == 0, "R7 shutdown clears all rails", rail_en, 0);
    check(rail_en[6:5] == 2'b00, "R10 aux forced off", rail_en[6:5], 0);
    aux_rail_req = 2'b00;

    // R1 / R4: charger start then loss
    chg_valid = 1'b1; cyc(5);
    check(rail_en[0], "R1 charger edge starts boot", rail_en[0], 1);
    cyc(60);
    check(cpu_rst_n, "R3 charger boot reset released", cpu_rst_n, 1);
    chg_valid = 1'b0; cyc(6);
    check(rail_en == 0, "R4 charger loss drops unclaimed boot", rail_en, 0);

    // R3: power-good lost at expiry
    rail1_pgood = 1'b0; pb_n = 1'b0; cyc(20);
    check(rail_en == 7'b0000001, "R1 waits for power-good", rail_en, 1);
    rail1_pgood = 1'b1; wait_rail2(seen);
    rail1_pgood = 1'b0; cyc(100);
    check(!cpu_rst_n && rail_en[1], "R3 reset held without power-good",
          {rail_en[1], cpu_rst_n}, 2'b10);
    rail1_pgood = 1'b1; cyc(40);
    check(cpu_rst_n, "R3 release once power-good returns", cpu_rst_n, 1);
    pb_n = 1'b1; cyc(20);
    check(rail_en == 0, "R4 unclaimed after retry", rail_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule